// File: doc/BRIEF.md
# Segmented Burst Store-and-Forward Buffer

This block decouples a DMA source datapath from a DMA sink datapath. Incoming beats are written into a dual-port memory that is split into `SEGMENTS` equal slots. Each slot holds exactly one burst of up to `BURST_BEATS` source beats. A burst becomes visible to the sink only once its closing beat, marked by `src_last`, has been stored. The sink then reads the burst back beat by beat, with `dst_last` on its final beat.

Flow control works per burst, not per beat. Occupancy is counted in bursts, so a one-beat burst uses a whole slot, and the next burst always starts at the base of the following slot. The block generates both valid/ready handshakes itself. It also converts between unequal source and sink widths:
- When the sink is wider, narrow beats are packed into wide words.
- When the sink is narrower, wide words are split into narrow beats.

Behind the memory's one-cycle read latency sits a two-word output stage, so sink backpressure never loses or repeats a beat.

Top module: `seg_burst_buffer`

## Requirements
- R1: After reset (`rst_n` low at a clock edge), `dst_valid` is low and `src_ready` is high, because all slots are empty.
- R2: The sink receives every stored beat exactly once, in the order the source delivered it, under any pattern of `src_valid` and `dst_ready` stalls; a stalled `dst_valid` beat keeps its data and last flag.
- R3: `dst_last` is high on exactly the final sink beat of each burst and low on every other beat.
- R4: No beat of a burst is offered to the sink before the source beat carrying `src_last` for that burst has been accepted.
- R5: A stored burst holds one slot whatever its length. `src_ready` is low whenever `SEGMENTS` bursts are held. The output stage holds up to two further memory words, and a burst frees its slot once its last word has been read from memory.
- R6: When `DST_W` is a multiple of `SRC_W`, source beats are packed lowest lane first. The first beat of each group goes to bits `[SRC_W-1:0]` of the sink word.
- R7: When packing, a burst whose length is not a multiple of `DST_W/SRC_W` ends with a sink word whose unused upper lanes are zero, and `dst_last` is set on that word.
- R8: When `SRC_W` is a multiple of `DST_W`, each stored word is sent lowest lane first as `SRC_W/DST_W` sink beats. `dst_last` falls on the final narrow beat of the burst's last word.
- R9: A burst of exactly `BURST_BEATS` source beats fits in one slot, and the following burst is placed in the next slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_valid | input | 1 | Source beat present |
| src_ready | output | 1 | Buffer can take a source beat |
| src_data | input | SRC_W | Source beat data |
| src_last | input | 1 | Marks the final beat of a source burst |
| dst_valid | output | 1 | Sink beat present |
| dst_ready | input | 1 | Sink takes the beat |
| dst_data | output | DST_W | Sink beat data |
| dst_last | output | 1 | Marks the final beat of a sink burst |

## Verification
The bench chains two instances:
- an 8-to-32-bit instance with four slots of sixteen bytes;
- a 32-to-8-bit instance with two slots of four words.

This single byte stream therefore exercises packing, zero-filled tails, unpacking and two different slot counts. It drives burst lengths from one to sixteen bytes under random stalls on both ends. With the sink frozen, it compares how many one-byte and how many sixteen-byte bursts the chain accepts. Both counts follow directly from burst-granular slot accounting plus the two-word output stage of each instance.

// File: rtl/sfb_pkg.sv
`timescale 1ns/1ps
// Shared helper functions for the segmented burst buffer.
// Assumes integer arguments that are positive.
package sfb_pkg;

    // Larger of two widths.
    function automatic int wider(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // How many narrow lanes fit into one wide word (1 if not narrower).
    function automatic int lanes_of(input int narrow, input int wide);
        return (wide > narrow) ? (wide / narrow) : 1;
    endfunction

    // Index width for n items, never below one bit.
    function automatic int bits_for(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/sfb_mem.sv
`timescale 1ns/1ps
// Simple dual-port memory: one write port, one read port, registered
// read data (one cycle of latency). Assumes the controller never reads
// and writes the same address in one cycle.
module sfb_mem #(
    parameter int W  = 32,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] store [DEPTH];

    // Write port.
    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (re) rdata <= store[raddr];
    end

endmodule

// File: rtl/sfb_wr_ctrl.sv
`timescale 1ns/1ps
// Source-side controller. Accepts beats while a slot is free, packs
// IN_R narrow beats into one memory word (IN_R = 1 means no packing),
// writes the word at {slot, offset} and, on the burst's last beat,
// reports the slot and the last word offset and moves to the next slot.
// Assumes SEGMENTS is a power of two and bursts fit one slot.
module sfb_wr_ctrl #(
    parameter int SRC_W     = 8,
    parameter int MW        = 32,
    parameter int IN_R      = 4,
    parameter int SEG_W     = 2,
    parameter int OFF_W     = 2,
    parameter int SEG_WORDS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   can_write,
    input  logic                   src_valid,
    output logic                   src_ready,
    input  logic [SRC_W-1:0]       src_data,
    input  logic                   src_last,
    output logic                   mem_we,
    output logic [SEG_W+OFF_W-1:0] mem_waddr,
    output logic [MW-1:0]          mem_wdata,
    output logic                   commit,
    output logic [SEG_W-1:0]       commit_seg,
    output logic [OFF_W-1:0]       commit_off
);
    localparam int LW = sfb_pkg::bits_for(IN_R);

    logic [LW-1:0]    lane;
    logic [MW-1:0]    acc;
    logic [MW-1:0]    word_n;
    logic [SEG_W-1:0] wseg;
    logic [OFF_W-1:0] woff;
    logic             take;
    logic             lane_end;
    logic             flush;

    assign take      = src_valid && can_write;
    assign lane_end  = (lane == LW'(IN_R - 1));
    assign flush     = take && (lane_end || src_last);
    assign src_ready = can_write;

    // Merge the incoming beat into the partly built word.
    always_comb begin
        word_n = acc;
        word_n[lane*SRC_W +: SRC_W] = src_data;
    end

    assign mem_we     = flush;
    assign mem_waddr  = {wseg, woff};
    assign mem_wdata  = word_n;
    assign commit     = take && src_last;
    assign commit_seg = wseg;
    assign commit_off = woff;

    // Advance lane, word offset and slot on accepted beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane <= '0;
            acc  <= '0;
            wseg <= '0;
            woff <= '0;
        end else if (take) begin
            if (flush) begin
                acc  <= '0;
                lane <= '0;
                woff <= src_last ? '0 : woff + 1'b1;
            end else begin
                acc  <= word_n;
                lane <= lane + 1'b1;
            end
            if (src_last) wseg <= wseg + 1'b1;
        end
    end

    // A word that does not close the burst must not be the slot's last word.
    assert_burst_fits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !src_last) |-> (woff != OFF_W'(SEG_WORDS - 1)));

endmodule

// File: rtl/sfb_rd_ctrl.sv
`timescale 1ns/1ps
// Sink-side controller. Reads stored bursts slot by slot, word by word,
// into a two-word output stage that absorbs the memory's read latency,
// then presents words directly (OUT_R = 1) or split into OUT_R narrow
// beats, lowest lane first. A slot is freed when its last word is read.
// Assumes have_burst is only high when the slot at rd_seg is complete.
module sfb_rd_ctrl #(
    parameter int MW    = 32,
    parameter int DST_W = 32,
    parameter int OUT_R = 1,
    parameter int SEG_W = 2,
    parameter int OFF_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   have_burst,
    input  logic [OFF_W-1:0]       last_off,
    output logic [SEG_W-1:0]       rd_seg,
    output logic                   mem_re,
    output logic [SEG_W+OFF_W-1:0] mem_raddr,
    input  logic [MW-1:0]          mem_rdata,
    output logic                   seg_free,
    output logic                   dst_valid,
    input  logic                   dst_ready,
    output logic [DST_W-1:0]       dst_data,
    output logic                   dst_last
);
    logic [SEG_W-1:0] rseg;
    logic [OFF_W-1:0] roff;
    logic             inflight;
    logic             inflight_last;
    logic [MW-1:0]    st_word [2];
    logic             st_last [2];
    logic             head;
    logic [1:0]       cnt;
    logic             wpos;
    logic             issue;
    logic             issue_last;
    logic             pop;
    logic             lane_end;
    logic [MW-1:0]    head_word;
    logic             head_last;

    assign issue      = have_burst && (((cnt + {1'b0, inflight}) < 2'd2) || pop);
    assign issue_last = issue && (roff == last_off);
    assign mem_re     = issue;
    assign mem_raddr  = {rseg, roff};
    assign rd_seg     = rseg;
    assign seg_free   = issue_last;
    assign wpos       = head ^ cnt[0];
    assign head_word  = st_word[head];
    assign head_last  = st_last[head];
    assign dst_valid  = (cnt != 2'd0);

    // Walk offsets within the current slot, then move to the next slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rseg          <= '0;
            roff          <= '0;
            inflight      <= 1'b0;
            inflight_last <= 1'b0;
        end else begin
            inflight      <= issue;
            inflight_last <= issue_last;
            if (issue) begin
                if (issue_last) begin
                    roff <= '0;
                    rseg <= rseg + 1'b1;
                end else begin
                    roff <= roff + 1'b1;
                end
            end
        end
    end

    // Output stage occupancy and head pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            head <= 1'b0;
        end else begin
            cnt <= cnt + {1'b0, inflight} - {1'b0, pop};
            if (pop) head <= ~head;
        end
    end

    // Output stage storage: capture read data one cycle after issue.
    always_ff @(posedge clk) begin
        if (inflight) begin
            st_word[wpos] <= mem_rdata;
            st_last[wpos] <= inflight_last;
        end
    end

    generate
        if (OUT_R > 1) begin : g_unpack
            localparam int LW = sfb_pkg::bits_for(OUT_R);
            logic [LW-1:0] lane;
            assign lane_end = (lane == LW'(OUT_R - 1));
            assign dst_data = head_word[lane*DST_W +: DST_W];
            // Step through the narrow lanes of the head word.
            always_ff @(posedge clk) begin
                if (!rst_n)                      lane <= '0;
                else if (dst_valid && dst_ready) lane <= lane_end ? '0 : lane + 1'b1;
            end
        end else begin : g_direct
            assign lane_end = 1'b1;
            assign dst_data = head_word[DST_W-1:0];
        end
    endgenerate

    assign dst_last = head_last && lane_end;
    assign pop      = dst_valid && dst_ready && lane_end;

    // A stalled beat keeps its content until taken.
    assert_hold_while_stalled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_valid && !dst_ready) |=> (dst_valid && $stable(dst_data) && $stable(dst_last)));

    // Returning read data always finds room in the output stage.
    assert_stage_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        inflight |-> ((cnt != 2'd2) || pop));

endmodule

// File: rtl/seg_burst_buffer.sv
`timescale 1ns/1ps
// Segmented burst store-and-forward buffer. A memory of SEGMENTS slots,
// each BURST_BEATS source beats deep, holds one burst per slot. The
// count of complete, not yet read bursts drives both handshakes: the
// source stalls when every slot is held, the sink is served only from
// complete bursts. Per-slot last-word offsets mark burst ends.
// Assumes SEGMENTS is a power of two (at least 2), the wider width is a
// whole multiple of the narrower, and BURST_BEATS is a multiple of the
// packing ratio.
module seg_burst_buffer #(
    parameter int SEGMENTS    = 4,
    parameter int BURST_BEATS = 16,
    parameter int SRC_W       = 8,
    parameter int DST_W       = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_valid,
    output logic             src_ready,
    input  logic [SRC_W-1:0] src_data,
    input  logic             src_last,
    output logic             dst_valid,
    input  logic             dst_ready,
    output logic [DST_W-1:0] dst_data,
    output logic             dst_last
);
    localparam int MW        = sfb_pkg::wider(SRC_W, DST_W);
    localparam int IN_R      = sfb_pkg::lanes_of(SRC_W, DST_W);
    localparam int OUT_R     = sfb_pkg::lanes_of(DST_W, SRC_W);
    localparam int SEG_WORDS = BURST_BEATS / IN_R;
    localparam int OFF_W     = sfb_pkg::bits_for(SEG_WORDS);
    localparam int SEG_W     = sfb_pkg::bits_for(SEGMENTS);
    localparam int ADDR_W    = SEG_W + OFF_W;
    localparam int CNT_W     = $clog2(SEGMENTS + 1);

    logic [CNT_W-1:0]  occupied;
    logic [OFF_W-1:0]  len_rec [SEGMENTS];
    logic              can_write;
    logic              have_burst;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [MW-1:0]     mem_wdata;
    logic              mem_re;
    logic [ADDR_W-1:0] mem_raddr;
    logic [MW-1:0]     mem_rdata;
    logic              commit;
    logic [SEG_W-1:0]  commit_seg;
    logic [OFF_W-1:0]  commit_off;
    logic [SEG_W-1:0]  rd_seg;
    logic              seg_free;
    logic [OFF_W-1:0]  last_off;

    assign can_write  = (occupied < CNT_W'(SEGMENTS));
    assign have_burst = (occupied != '0);
    assign last_off   = len_rec[rd_seg];

    // Count complete bursts still holding a slot.
    always_ff @(posedge clk) begin
        if (!rst_n) occupied <= '0;
        else        occupied <= occupied + CNT_W'(commit) - CNT_W'(seg_free);
    end

    // Record each burst's last word offset in its slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SEGMENTS; i++) len_rec[i] <= '0;
        end else if (commit) begin
            len_rec[commit_seg] <= commit_off;
        end
    end

    sfb_wr_ctrl #(
        .SRC_W(SRC_W), .MW(MW), .IN_R(IN_R),
        .SEG_W(SEG_W), .OFF_W(OFF_W), .SEG_WORDS(SEG_WORDS)
    ) u_wr (
        .clk(clk), .rst_n(rst_n), .can_write(can_write),
        .src_valid(src_valid), .src_ready(src_ready),
        .src_data(src_data), .src_last(src_last),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .commit(commit), .commit_seg(commit_seg), .commit_off(commit_off)
    );

    sfb_mem #(.W(MW), .AW(ADDR_W)) u_mem (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .re(mem_re), .raddr(mem_raddr), .rdata(mem_rdata)
    );

    sfb_rd_ctrl #(
        .MW(MW), .DST_W(DST_W), .OUT_R(OUT_R),
        .SEG_W(SEG_W), .OFF_W(OFF_W)
    ) u_rd (
        .clk(clk), .rst_n(rst_n), .have_burst(have_burst),
        .last_off(last_off), .rd_seg(rd_seg),
        .mem_re(mem_re), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
        .seg_free(seg_free),
        .dst_valid(dst_valid), .dst_ready(dst_ready),
        .dst_data(dst_data), .dst_last(dst_last)
    );

    // Slot count never exceeds the number of slots.
    assert_occupancy_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        occupied <= CNT_W'(SEGMENTS));

    // Accepting a closing beat leaves at least one complete burst held.
    assert_commit_counts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (src_valid && src_ready && src_last) |=> (occupied != '0));

    // The sink sees a new beat only if a complete burst was held two cycles earlier.
    assert_offer_after_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dst_valid) |-> $past(occupied != '0, 2));

endmodule

// File: tb/seg_burst_buffer_bench.sv
`timescale 1ns/1ps
// Chained bench: 8->32 instance feeding a 32->8 instance; scoreboard on bytes.
module seg_burst_buffer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_valid = 1'b0;
    logic        a_ready;
    logic [7:0]  a_data = '0;
    logic        a_last = 1'b0;
    logic        mid_valid;
    logic        mid_ready;
    logic [31:0] mid_data;
    logic        mid_last;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_data;
    logic        out_last;

    int          n_checks = 0;
    int          n_fail = 0;
    int          ready_pct = 0;
    logic [7:0]  exp_d [$];
    bit          exp_l [$];
    logic [31:0] mid_word = '0;
    logic        mid_seen_last = 1'b0;
    int          got;

    always #2.5 clk = ~clk;

    seg_burst_buffer #(.SEGMENTS(4), .BURST_BEATS(16), .SRC_W(8), .DST_W(32)) u_seg_burst_buffer (
        .clk(clk), .rst_n(rst_n),
        .src_valid(a_valid), .src_ready(a_ready), .src_data(a_data), .src_last(a_last),
        .dst_valid(mid_valid), .dst_ready(mid_ready), .dst_data(mid_data), .dst_last(mid_last)
    );

    seg_burst_buffer #(.SEGMENTS(2), .BURST_BEATS(4), .SRC_W(32), .DST_W(8)) u_seg_burst_buffer_narrow (
        .clk(clk), .rst_n(rst_n),
        .src_valid(mid_valid), .src_ready(mid_ready), .src_data(mid_data), .src_last(mid_last),
        .dst_valid(out_valid), .dst_ready(out_ready), .dst_data(out_data), .dst_last(out_last)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Zero lanes that complete a partial wide word (R7).
    task automatic push_pad(input int len);
        int pad;
        pad = (4 - (len % 4)) % 4;
        for (int p = 0; p < pad; p++) begin
            exp_d.push_back(8'h00);
            exp_l.push_back(p == pad - 1);
        end
    endtask

    // Driver: one burst with random source gaps; optional hold before the last beat.
    task automatic send_burst(input int len, input int gap_pct, input int hold, input logic [7:0] first);
        for (int i = 0; i < len; i++) begin
            while (int'($urandom % 100) < gap_pct) begin
                a_valid = 1'b0;
                @(posedge clk); #1;
            end
            if (i == len - 1 && hold > 0) begin
                a_valid = 1'b0;
                repeat (hold) @(posedge clk);
                #1;
                check(!out_valid && !mid_valid, "R4", {30'd0, mid_valid, out_valid}, 32'd0);
            end
            a_valid = 1'b1;
            a_data  = (first == 8'h00) ? 8'($urandom) : 8'(first + 8'(i * 17));
            a_last  = (i == len - 1);
            forever begin
                @(negedge clk);
                if (a_ready) break;
            end
            exp_d.push_back(a_data);
            exp_l.push_back((i == len - 1) && (len % 4 == 0));
            @(posedge clk); #1;
        end
        a_valid = 1'b0;
        a_last  = 1'b0;
        push_pad(len);
    endtask

    // Offer back-to-back bursts of blen bytes for a number of cycles; count accepted bursts.
    task automatic fill(input int blen, input int cycles, output int bursts);
        int k;
        k = 0;
        bursts = 0;
        for (int c = 0; c < cycles; c++) begin
            a_valid = 1'b1;
            a_data  = 8'(k * 7 + 3);
            a_last  = ((k % blen) == blen - 1);
            @(negedge clk);
            if (a_ready) begin
                exp_d.push_back(a_data);
                exp_l.push_back(a_last && (blen % 4 == 0));
                if (a_last) begin
                    bursts++;
                    push_pad(blen);
                end
                k++;
            end
            @(posedge clk); #1;
        end
        a_valid = 1'b0;
        a_last  = 1'b0;
    endtask

    task automatic wait_drain();
        for (int c = 0; c < 3000 && exp_d.size() != 0; c++) @(posedge clk);
        repeat (10) @(posedge clk);
        #1;
        check(exp_d.size() == 0, "R2", exp_d.size(), 0);
    endtask

    // Sink ready pattern, changed just after each rising edge.
    always @(posedge clk) begin
        #1;
        out_ready = (int'($urandom % 100) < ready_pct);
    end

    // Monitor: compare every delivered byte with the scoreboard.
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (exp_d.size() == 0) begin
                check(1'b0, "R2", {24'd0, out_data}, 32'd0);
            end else begin
                logic [7:0] d;
                bit l;
                d = exp_d.pop_front();
                l = exp_l.pop_front();
                check(out_data == d, "R2 R8 data", {24'd0, out_data}, {24'd0, d});
                check(out_last == l, "R3 R7 last", {31'd0, out_last}, {31'd0, l});
            end
        end
    end

    // Capture wide words crossing between the two instances.
    always @(negedge clk) begin
        if (rst_n && mid_valid && mid_ready) begin
            mid_word      = mid_data;
            mid_seen_last = mid_last;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        report();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: empty after reset
        check(!out_valid, "R1 out_valid", {31'd0, out_valid}, 0);
        check(!mid_valid, "R1 mid_valid", {31'd0, mid_valid}, 0);
        check(a_ready, "R1 src_ready", {31'd0, a_ready}, 1);
        @(posedge clk); #1;

        // R6: four bytes pack lowest lane first
        ready_pct = 100;
        send_burst(4, 0, 0, 8'h11);
        repeat (20) @(posedge clk);
        #1;
        check(mid_word == 32'h77665544 - 32'h33333333 + 32'h00000000 && mid_seen_last,
              "R6 packed word", mid_word, 32'h44332211);
        wait_drain();

        // R7: three-byte tail zero-filled, last on the wide word
        send_burst(3, 0, 0, 8'hAA);
        repeat (20) @(posedge clk);
        #1;
        check(mid_word == 32'h00CCBBAA, "R7 tail word", mid_word, 32'h00CCBBAA);
        check(mid_seen_last, "R7 tail last", {31'd0, mid_seen_last}, 1);
        wait_drain();

        // R4: burst withheld until its closing beat arrives
        send_burst(8, 0, 30, 8'h00);
        wait_drain();

        // R2 R3: random lengths with stalls on both sides, including 1 and 16
        ready_pct = 60;
        send_burst(1, 30, 0, 8'h00);
        send_burst(16, 30, 0, 8'h00);
        for (int b = 0; b < 40; b++) send_burst(1 + int'($urandom % 16), 30, 0, 8'h00);
        send_burst(16, 0, 0, 8'h00);
        send_burst(1, 0, 0, 8'h00);
        wait_drain();

        // R5: frozen sink, one-byte bursts: 4+2 in first, 2+2 in second
        ready_pct = 0;
        repeat (5) @(posedge clk);
        #1;
        fill(1, 150, got);
        check(got == 10, "R5 one-byte bursts held", got, 10);
        check(!a_ready, "R5 source stalled", {31'd0, a_ready}, 0);
        ready_pct = 100;
        wait_drain();

        // R9: frozen sink, full-length bursts use one slot each
        ready_pct = 0;
        repeat (5) @(posedge clk);
        #1;
        fill(16, 300, got);
        check(got == 6, "R9 full bursts held", got, 6);
        ready_pct = 100;
        wait_drain();

        report();
    end

endmodule